// File: doc/BRIEF.md
# Interleaved-Parity Word Guard for a Write-Back Data Cache

This block protects 64-bit data-cache words with eight parity bits whose groups are spread across the word. Data bit j is covered by check bit j mod 8, so any run of up to eight neighbouring bits that an upset flips touches each group at most once and is always seen. On a store, the block produces the word and check bits to be written. On a load, it recomputes parity over the stored word and compares it with the stored check bits.

The array read happens outside the block. Each request therefore arrives with the stored word, the stored check bits and the line's dirty flag in the same cycle. A store that writes all eight bytes takes its check bits straight from the new data and ignores the stored word. A store that writes only some bytes is a read-modify-write. The new bytes are merged over the stored word and parity is recomputed over the result. The stored word is checked first. If it is damaged, the write is dropped.

A detected error is classified by the dirty flag. In a clean line the correct copy still exists one level down, so the block raises a refetch request and the line is treated as a miss. In a dirty line the only copy is lost, so the block raises an uncorrectable-error flag. All results appear one cycle after the request, tagged with the request's word index.

Top module: `l1_ipar_guard`

## Requirements
- R1: While reset is held, and in the first cycles after it is released, `wr_en_o`, `refetch_o` and `uncorr_o` stay low, even if requests are presented.
- R2: The parity is even. Check bit g (bit g of the 8-bit check field) is the XOR of every data bit j with j mod 8 = g. Written check bits follow this rule for the written word.
- R3: On a read, flipping any run of 1 to 8 adjacent stored data bits, or any single stored check bit, is detected.
- R4: A read that finds a parity mismatch with `req_dirty_i`=0 raises `refetch_o` and not `uncorr_o`, one cycle after the request.
- R5: A read that finds a parity mismatch with `req_dirty_i`=1 raises `uncorr_o` and not `refetch_o`, one cycle after the request.
- R6: A write with all byte enables set (`req_be_i`=8'hFF) outputs `wr_data_o` equal to the write data with parity per R2. It raises no error flag, even when the stored word or stored check bits are corrupt.
- R7: A write with any byte enable clear outputs a merged word. Byte lane b (bits 8b+7..8b) comes from the write data when `req_be_i[b]`=1 and from the stored word otherwise. Parity is computed per R2 over the merged word.
- R8: A partial write whose stored word fails parity keeps `wr_en_o` low and raises `refetch_o` or `uncorr_o` by the dirty flag, exactly as a read would.
- R9: `out_idx_o` equals the `req_idx_i` of the request whose results are shown.
- R10: A cycle with `req_valid_i`=0 gives all flags low in the next cycle, whatever the other inputs are. A read with matching parity raises no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 = store, 0 = load |
| req_be_i | input | 8 | Byte enables of a store |
| req_wdata_i | input | 64 | Store data |
| req_idx_i | input | 6 | Word index of the request |
| req_dirty_i | input | 1 | Line holding the word is dirty |
| st_data_i | input | 64 | Word currently in the array |
| st_par_i | input | 8 | Check bits currently in the array |
| wr_en_o | output | 1 | Write word and check bits to the array |
| wr_data_o | output | 64 | Word to write |
| wr_par_o | output | 8 | Check bits to write |
| refetch_o | output | 1 | Error in a clean line: refetch as a miss |
| uncorr_o | output | 1 | Error in a dirty line: uncorrectable |
| out_idx_o | output | 6 | Word index for the current outputs |

## Verification
The hardest case to reach is a read-modify-write whose stored word is damaged. To get there, the store must leave a byte enable clear, the stored word must be given a flip that parity sees, and the dirty flag must be chosen for each outcome. The vector table places such stores in both clean and dirty lines, next to full stores over corrupt data, which must still write. A directed sweep then places bursts of every length from one to eight at every bit offset, with a changing index. A few non-detected cases, two flips in one group, confirm the group mapping from the outside.

// File: rtl/ipar_pkg.sv
package ipar_pkg;
  localparam int unsigned WORD_W_DEF = 64;
  localparam int unsigned CHK_W_DEF  = 8;
  localparam int unsigned IDX_W_DEF  = 6;
  localparam int unsigned LANE_W     = 8;
endpackage

// File: rtl/ipar_rst_sync.sv
module ipar_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/ipar_gen.sv
module ipar_gen #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned CHK_W  = 8
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CHK_W-1:0]  par_o
);
  for (genvar g = 0; g < CHK_W; g++) begin : g_grp
    logic grp_p;
    always_comb begin
      grp_p = 1'b0;
      for (int j = g; j < DATA_W; j += CHK_W) grp_p = grp_p ^ data_i[j];
    end
    assign par_o[g] = grp_p;
  end
endmodule

// File: rtl/ipar_merge.sv
module ipar_merge #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned LANES = DATA_W / LANE_W
) (
  input  logic [LANES-1:0]  be_i,
  input  logic [DATA_W-1:0] new_i,
  input  logic [DATA_W-1:0] old_i,
  output logic [DATA_W-1:0] merged_o
);
  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign merged_o[b*LANE_W +: LANE_W] =
      be_i[b] ? new_i[b*LANE_W +: LANE_W] : old_i[b*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/ipar_stage.sv
module ipar_stage #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned CHK_W  = 8,
  parameter int unsigned IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic              req_full_i,
  input  logic              req_dirty_i,
  input  logic [IDX_W-1:0]  req_idx_i,
  input  logic              stored_err_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CHK_W-1:0]  wpar_i,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [CHK_W-1:0]  wr_par_o,
  output logic              refetch_o,
  output logic              uncorr_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic need_chk, err_hit;
  logic wr_en_d, refetch_d, uncorr_d;

  always_comb begin
    need_chk  = !req_write_i || !req_full_i;
    err_hit   = req_valid_i && need_chk && stored_err_i;
    wr_en_d   = req_valid_i && req_write_i && !err_hit;
    refetch_d = err_hit && !req_dirty_i;
    uncorr_d  = err_hit && req_dirty_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en_o   <= 1'b0;
      refetch_o <= 1'b0;
      uncorr_o  <= 1'b0;
    end else begin
      wr_en_o   <= wr_en_d;
      refetch_o <= refetch_d;
      uncorr_o  <= uncorr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_data_o <= '0;
      wr_par_o  <= '0;
      idx_o     <= '0;
    end else if (req_valid_i) begin
      wr_data_o <= wdata_i;
      wr_par_o  <= wpar_i;
      idx_o     <= req_idx_i;
    end
  end

  assert_flag_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(refetch_o && uncorr_o));

  assert_no_write_on_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_o && (refetch_o || uncorr_o)));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid_i |=> (!wr_en_o && !refetch_o && !uncorr_o));

  assert_full_store_ok_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_write_i && req_full_i) |=> (wr_en_o && !refetch_o && !uncorr_o));

  assert_clean_refetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && !req_write_i && stored_err_i && !req_dirty_i) |=> refetch_o);
endmodule

// File: rtl/l1_ipar_guard.sv
module l1_ipar_guard #(
  parameter int unsigned WORD_W = ipar_pkg::WORD_W_DEF,
  parameter int unsigned CHK_W  = ipar_pkg::CHK_W_DEF,
  parameter int unsigned IDX_W  = ipar_pkg::IDX_W_DEF,
  localparam int unsigned LANES = WORD_W / ipar_pkg::LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [LANES-1:0]  req_be_i,
  input  logic [WORD_W-1:0] req_wdata_i,
  input  logic [IDX_W-1:0]  req_idx_i,
  input  logic              req_dirty_i,
  input  logic [WORD_W-1:0] st_data_i,
  input  logic [CHK_W-1:0]  st_par_i,
  output logic              wr_en_o,
  output logic [WORD_W-1:0] wr_data_o,
  output logic [CHK_W-1:0]  wr_par_o,
  output logic              refetch_o,
  output logic              uncorr_o,
  output logic [IDX_W-1:0]  out_idx_o
);
  logic              rst_n_s;
  logic [CHK_W-1:0]  st_recalc;
  logic [WORD_W-1:0] merged;
  logic [CHK_W-1:0]  merged_par;
  logic [CHK_W-1:0]  out_recalc;
  logic              stored_err;
  logic              full_store;

  ipar_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_o(rst_n_s)
  );

  ipar_gen #(.DATA_W(WORD_W), .CHK_W(CHK_W)) u_gen_st (
    .data_i(st_data_i), .par_o(st_recalc)
  );

  ipar_merge #(.DATA_W(WORD_W), .LANE_W(ipar_pkg::LANE_W)) u_merge (
    .be_i(req_be_i), .new_i(req_wdata_i), .old_i(st_data_i), .merged_o(merged)
  );

  ipar_gen #(.DATA_W(WORD_W), .CHK_W(CHK_W)) u_gen_wr (
    .data_i(merged), .par_o(merged_par)
  );

  always_comb begin
    stored_err = |(st_recalc ^ st_par_i);
    full_store = &req_be_i;
  end

  ipar_stage #(.DATA_W(WORD_W), .CHK_W(CHK_W), .IDX_W(IDX_W)) u_stage (
    .clk(clk), .rst_n(rst_n_s),
    .req_valid_i(req_valid_i), .req_write_i(req_write_i),
    .req_full_i(full_store), .req_dirty_i(req_dirty_i),
    .req_idx_i(req_idx_i), .stored_err_i(stored_err),
    .wdata_i(merged), .wpar_i(merged_par),
    .wr_en_o(wr_en_o), .wr_data_o(wr_data_o), .wr_par_o(wr_par_o),
    .refetch_o(refetch_o), .uncorr_o(uncorr_o), .idx_o(out_idx_o)
  );

  ipar_gen #(.DATA_W(WORD_W), .CHK_W(CHK_W)) u_gen_out (
    .data_i(wr_data_o), .par_o(out_recalc)
  );

  assert_wr_par_even_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    wr_en_o |-> (out_recalc == wr_par_o));

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n_s |-> (!wr_en_o && !refetch_o && !uncorr_o));
endmodule

// File: tb/l1_ipar_guard_tb_top.sv
`timescale 1ns/100ps
module l1_ipar_guard_tb_top;
  localparam int VW = 210;
  localparam int NV = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid_i = 1'b0, req_write_i = 1'b0, req_dirty_i = 1'b0;
  logic [7:0]  req_be_i = '0;
  logic [63:0] req_wdata_i = '0, st_data_i = '0;
  logic [5:0]  req_idx_i = '0;
  logic [7:0]  st_par_i = '0;
  logic        wr_en_o, refetch_o, uncorr_o;
  logic [63:0] wr_data_o;
  logic [7:0]  wr_par_o;
  logic [5:0]  out_idx_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  l1_ipar_guard dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .req_write_i(req_write_i),
    .req_be_i(req_be_i), .req_wdata_i(req_wdata_i), .req_idx_i(req_idx_i),
    .req_dirty_i(req_dirty_i), .st_data_i(st_data_i), .st_par_i(st_par_i),
    .wr_en_o(wr_en_o), .wr_data_o(wr_data_o), .wr_par_o(wr_par_o),
    .refetch_o(refetch_o), .uncorr_o(uncorr_o), .out_idx_o(out_idx_o)
  );

  // fields: wr, be, wdata, sdata, flip, pflip, dirty
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b0, 8'h00, 64'h0, 64'hA5A5_A5A5_0F0F_F0F0, 64'h0, 8'h00, 1'b0},
    {1'b0, 8'h00, 64'h0, 64'h1234_5678_9ABC_DEF0, 64'h1, 8'h00, 1'b0},
    {1'b0, 8'h00, 64'h0, 64'hFFFF_0000_FFFF_0000, 64'h78, 8'h00, 1'b1},
    {1'b1, 8'hFF, 64'hDEAD_BEEF_CAFE_F00D, 64'h0, 64'hFF00, 8'h11, 1'b1},
    {1'b1, 8'h0F, 64'h1111_2222_3333_4444, 64'hAAAA_BBBB_CCCC_DDDD, 64'h0, 8'h00, 1'b0},
    {1'b1, 8'hF0, 64'h5555_6666_7777_8888, 64'h0102_0304_0506_0708, 64'h8000, 8'h00, 1'b1},
    {1'b0, 8'h00, 64'h0, 64'h0F0F_0F0F_0F0F_0F0F, 64'h0, 8'h20, 1'b1},
    {1'b0, 8'h00, 64'h0, 64'h0, 64'h101, 8'h00, 1'b0},
    {1'b1, 8'h00, 64'h9999_9999_9999_9999, 64'h7654_3210_FEDC_BA98, 64'h0, 8'h00, 1'b0},
    {1'b1, 8'h3C, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h4_0000_0000, 8'h00, 1'b0}
  };

  function automatic logic [7:0] gpar(input logic [63:0] d);
    logic [7:0] p = '0;
    for (int j = 0; j < 64; j++) p[j % 8] ^= d[j];
    return p;
  endfunction

  task automatic check(input string tag, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // entered at a negedge; returns at the following negedge after checking
  task automatic run_op(input string tag, input logic wr, input logic [7:0] be,
                        input logic [63:0] wd, input logic [63:0] sd, input logic [63:0] fl,
                        input logic [7:0] pf, input logic dty, input logic [5:0] idx);
    logic [63:0] stored, merged;
    logic [7:0]  spar;
    logic perr, err, e_wr;
    spar   = gpar(sd) ^ pf;
    stored = sd ^ fl;
    perr   = gpar(stored) != spar;
    err    = (!wr || !(&be)) && perr;
    e_wr   = wr && !err;
    for (int b = 0; b < 8; b++) merged[b*8 +: 8] = be[b] ? wd[b*8 +: 8] : stored[b*8 +: 8];
    req_valid_i = 1'b1; req_write_i = wr; req_be_i = be; req_wdata_i = wd;
    st_data_i = stored; st_par_i = spar; req_dirty_i = dty; req_idx_i = idx;
    @(negedge clk);
    check({tag, " flags/R9 idx"}, {71'd0, wr_en_o, refetch_o, uncorr_o, out_idx_o},
          {71'd0, e_wr, err && !dty, err && dty, idx});
    if (e_wr) check({tag, " data/R2 par"}, {8'd0, wr_data_o, wr_par_o}, {8'd0, merged, gpar(merged)});
    req_valid_i = 1'b0;
  endtask

  initial begin
    #500000;
    if (!done) begin
      done = 1; n_bad++; n_chk++;
      $display("FAIL watchdog R1 actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: requests during reset are ignored
    repeat (2) @(negedge clk);
    req_valid_i = 1'b1; req_write_i = 1'b0; st_data_i = 64'h1; st_par_i = 8'h00;
    @(negedge clk);
    check("R1 in reset", {77'd0, wr_en_o, refetch_o, uncorr_o}, 80'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {77'd0, wr_en_o, refetch_o, uncorr_o}, 80'd0);
    req_valid_i = 1'b0;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      run_op("R4 R5 R6 R7 R8 vector", v[209], v[208:201], v[200:137], v[136:73],
             v[72:9], v[8:1], v[0], 6'(i));
    end

    // R10: idle cycle with corrupt inputs raises nothing
    req_valid_i = 1'b0; req_write_i = 1'b0; st_data_i = 64'hF; st_par_i = 8'h00;
    @(negedge clk);
    @(negedge clk);
    check("R10 idle", {77'd0, wr_en_o, refetch_o, uncorr_o}, 80'd0);

    // R3: bursts of 1..8 adjacent bits at every offset
    for (int s = 0; s < 64; s++) begin
      for (int l = 1; l <= 8; l++) begin
        if (s + l <= 64) begin
          logic [63:0] m;
          m = ((64'd1 << l) - 64'd1) << s;
          run_op("R3 burst", 1'b0, 8'h00, 64'h0, 64'hC3C3_5A5A_9696_0FF0 ^ 64'(s),
                 m, 8'h00, 1'(l & 1), 6'(s));
        end
      end
    end
    for (int g = 0; g < 8; g++)
      run_op("R3 check bit", 1'b0, 8'h00, 64'h0, 64'h0123_4567_89AB_CDEF,
             64'h0, 8'(1 << g), 1'b0, 6'(g));

    // R8: partial writes into a damaged word, clean and dirty
    run_op("R8 clean", 1'b1, 8'h01, 64'hFF, 64'h0, 64'h100, 8'h00, 1'b0, 6'd33);
    run_op("R8 dirty", 1'b1, 8'h7F, 64'h0, 64'h0, 64'h0, 8'h80, 1'b1, 6'd34);
    // R6: full write over corrupt parity still writes
    run_op("R6 full", 1'b1, 8'hFF, 64'h0, 64'h0, 64'hFFFF_FFFF, 8'hFF, 1'b0, 6'd63);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule